// File: doc/BRIEF.md
# Inter-Word Gap Detector

This block sits behind the bit sampler of a serial avionics-style receiver and decides when the line has been idle long enough for a new word to be accepted. It does not measure one continuous idle time. When a reception ends, it starts a repeating spot-check. Every check interval, which is 10 reference clocks at high speed and 80 at low speed, it looks at two qualified-null flags. One flag covers the newer half of the null sample history and the other covers the older half. A check passes only when both flags are set. Each passing check advances a small gap counter. When the counter reaches three, the receive-enable level to the sampler goes high.

A failing check throws the progress away. The counter returns to zero and waits for a fresh run of three passing checks. The following events also restart the counter and the interval timer and pull receive-enable low:
- a last-bit pulse from the sampler, which marks the end of a reception, whether valid or aborted;
- a change of the speed mode.

After reset the detector starts checking at once. The line must therefore show a valid gap before the first word is taken.

Top module: `gap_guard`

## Requirements
- R1: While reset is held, and on the first cycle after it, rxEnable is low. Checking starts at once after reset: at high speed with both null flags high, rxEnable rises on the 30th clock edge after the last edge with reset asserted.
- R2: In high-speed mode (lowSpeed=0) the null flags are sampled on every 10th clock edge after a restart. With both flags held high, rxEnable is low after edge 29 and high after edge 30.
- R3: In low-speed mode (lowSpeed=1) the sampling period is 80 clocks. With both flags held high, rxEnable is low after edge 239 and high after edge 240 counted from the restart.
- R4: A check passes only if nullUpper and nullLower are both high at the sampling edge. If only one of them is high, the check fails.
- R5: A failing check clears the gap counter, so three further passing checks are needed before rxEnable rises.
- R6: Null flag values on edges that are not sampling edges have no effect. Flags that are high only on sampling edges still enable after three checks.
- R7: A lastBitPulse sampled at an edge forces rxEnable low after that edge and restarts both the counter and the interval timer from that edge.
- R8: A change of lowSpeed between edges clears the counter and the timer at the edge where the change is seen, and rxEnable is low after it.
- R9: The counter saturates at three. Once rxEnable is high it stays high, whatever the null flags do, until a lastBitPulse or a speed change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; all timing counts its rising edges |
| rstN | input | 1 | Synchronous active-low reset |
| lowSpeed | input | 1 | Speed select: 0 = 10-clock check period, 1 = 80-clock check period |
| lastBitPulse | input | 1 | One-cycle marker of the final data bit of a reception |
| nullUpper | input | 1 | Qualified null seen in the newer half of the null history |
| nullLower | input | 1 | Qualified null seen in the older half of the null history |
| rxEnable | output | 1 | High when the next reception may start |

## Verification
The hardest case to reach from the ports is proving that only the sampling edges matter. The flags must be high on exactly the check edges and low everywhere else, and a single failing check must be placed between passing ones. The bench counts clock edges from each restart point and drives the flags high only on edges that are multiples of the period. It then moves one failing sample, with only one flag high, onto a specific check edge. A behavioural model that tracks a plain integer timer and counter is compared on every clock. It catches any drift of the sampling point by even one edge.

// File: rtl/gap_guard_pkg.sv
package gap_guard_pkg;

  // Strobes sent from control to datapath each cycle
  typedef struct packed {
    logic restart;    // clear timer and counter
    logic checkPass;  // sampling edge with both nulls present
    logic checkFail;  // sampling edge with a missing null
  } gap_strobe_t;

endpackage

// File: rtl/gap_guard_ctrl.sv
module gap_guard_ctrl
  import gap_guard_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        lowSpeed,
  input  logic        lastBitPulse,
  input  logic        nullUpper,
  input  logic        nullLower,
  input  logic        intervalDone,
  input  logic        gapFull,
  output gap_strobe_t strobe
);

  logic modeReg;
  logic modeChange;
  logic bothNull;
  logic evalNow;

  // Remember the speed seen on the previous edge; a difference restarts
  always_ff @(posedge clk) begin
    modeReg <= lowSpeed;
  end

  assign modeChange = rstN && (lowSpeed != modeReg);
  assign bothNull   = nullUpper && nullLower;

  always_comb begin
    strobe.restart   = lastBitPulse || modeChange;
    evalNow          = intervalDone && !gapFull && !strobe.restart;
    strobe.checkPass = evalNow && bothNull;
    strobe.checkFail = evalNow && !bothNull;
  end

endmodule

// File: rtl/gap_guard_dp.sv
module gap_guard_dp
  import gap_guard_pkg::*;
#(
  parameter int HS_PERIOD  = 10,
  parameter int LS_PERIOD  = 80,
  parameter int GAP_CHECKS = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        lowSpeed,
  input  gap_strobe_t strobe,
  output logic        intervalDone,
  output logic        gapFull
);

  localparam int MAX_PERIOD = (LS_PERIOD > HS_PERIOD) ? LS_PERIOD : HS_PERIOD;
  localparam int TIMER_W    = $clog2(MAX_PERIOD);
  localparam int CNT_W      = $clog2(GAP_CHECKS + 1);
  localparam logic [TIMER_W-1:0] HS_LAST = TIMER_W'(HS_PERIOD - 1);
  localparam logic [TIMER_W-1:0] LS_LAST = TIMER_W'(LS_PERIOD - 1);
  localparam logic [CNT_W-1:0]   CNT_TOP = CNT_W'(GAP_CHECKS);

  logic [TIMER_W-1:0] intervalTimer;
  logic [TIMER_W-1:0] timerLast;
  logic [CNT_W-1:0]   gapCount;

  assign timerLast    = lowSpeed ? LS_LAST : HS_LAST;
  assign intervalDone = (intervalTimer == timerLast);
  assign gapFull      = (gapCount == CNT_TOP);

  // Interval timer: runs freely, wraps at the sampling edge
  always_ff @(posedge clk) begin
    if (!rstN || strobe.restart || intervalDone) begin
      intervalTimer <= '0;
    end else begin
      intervalTimer <= intervalTimer + 1'b1;
    end
  end

  // Gap counter: advances on a pass, clears on a fail, holds when full
  always_ff @(posedge clk) begin
    if (!rstN || strobe.restart || strobe.checkFail) begin
      gapCount <= '0;
    end else if (strobe.checkPass) begin
      gapCount <= gapCount + 1'b1;
    end
  end

endmodule

// File: rtl/gap_guard.sv
module gap_guard
  import gap_guard_pkg::*;
#(
  parameter int HS_PERIOD  = 10,
  parameter int LS_PERIOD  = 80,
  parameter int GAP_CHECKS = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic lowSpeed,
  input  logic lastBitPulse,
  input  logic nullUpper,
  input  logic nullLower,
  output logic rxEnable
);

  gap_strobe_t strobe;
  logic        intervalDone;
  logic        gapFull;

  gap_guard_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .lowSpeed     (lowSpeed),
    .lastBitPulse (lastBitPulse),
    .nullUpper    (nullUpper),
    .nullLower    (nullLower),
    .intervalDone (intervalDone),
    .gapFull      (gapFull),
    .strobe       (strobe)
  );

  gap_guard_dp #(
    .HS_PERIOD  (HS_PERIOD),
    .LS_PERIOD  (LS_PERIOD),
    .GAP_CHECKS (GAP_CHECKS)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .lowSpeed     (lowSpeed),
    .strobe       (strobe),
    .intervalDone (intervalDone),
    .gapFull      (gapFull)
  );

  assign rxEnable = gapFull;

endmodule

// File: rtl/gap_guard_chk.sv
module gap_guard_chk (
  input logic clk,
  input logic rstN,
  input logic lowSpeed,
  input logic lastBitPulse,
  input logic nullUpper,
  input logic nullLower,
  input logic rxEnable
);

  // R1: reset leaves the enable low
  a_r1_reset_low: assert property (@(posedge clk) !rstN |=> !rxEnable);

  // R7: a last-bit marker drops the enable
  a_r7_drop_after_last: assert property (@(posedge clk) disable iff (!rstN)
    lastBitPulse |=> !rxEnable);

  // R8: a speed change drops the enable
  a_r8_drop_on_mode: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(lowSpeed) |=> !rxEnable);

  // R4: enable can only rise after a sampling edge with both nulls present
  a_r4_rise_needs_both: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxEnable) |-> $past(nullUpper && nullLower));

  // R7: enable never rises right after a last-bit marker
  a_r7_no_rise_on_last: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxEnable) |-> !$past(lastBitPulse));

  // R9: once high, the enable holds until a marker or a speed change
  a_r9_hold_high: assert property (@(posedge clk) disable iff (!rstN)
    (rxEnable && !lastBitPulse && $stable(lowSpeed)) |=> rxEnable);

endmodule

bind gap_guard gap_guard_chk u_chk (.*);

// File: tb/gap_guard_bench.sv
module gap_guard_bench;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lowSpeed = 1'b0;
  logic lastBitPulse = 1'b0;
  logic nullUpper = 1'b0;
  logic nullLower = 1'b0;
  logic rxEnable;

  int    checks = 0;
  int    fails = 0;
  string curReq = "R1";
  bit    done = 1'b0;

  // Behavioural reference
  int mTimer = 0;
  int mCount = 0;
  bit mMode  = 1'b0;

  always #2 clk = ~clk;

  gap_guard u_gap_guard (
    .clk          (clk),
    .rstN         (rstN),
    .lowSpeed     (lowSpeed),
    .lastBitPulse (lastBitPulse),
    .nullUpper    (nullUpper),
    .nullLower    (nullLower),
    .rxEnable     (rxEnable)
  );

  always @(posedge clk) begin
    int per;
    per = lowSpeed ? 80 : 10;
    if (!rstN) begin
      mTimer = 0;
      mCount = 0;
    end else if (lastBitPulse || (lowSpeed != mMode)) begin
      mTimer = 0;
      mCount = 0;
    end else if (mTimer == per - 1) begin
      mTimer = 0;
      if (mCount < 3) mCount = (nullUpper && nullLower) ? mCount + 1 : 0;
    end else begin
      mTimer = mTimer + 1;
    end
    mMode = lowSpeed;
  end

  // Compare against the model on every clock, away from the edge
  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (rxEnable !== (mCount == 3)) begin
        fails++;
        $display("FAIL %s model compare: rxEnable=%0b expected=%0b at %0t",
                 curReq, rxEnable, (mCount == 3), $time);
      end
    end
  end

  task automatic expectEn(input bit exp, input string req);
    checks++;
    if (rxEnable !== exp) begin
      fails++;
      $display("FAIL %s directed: rxEnable=%0b expected=%0b at %0t", req, rxEnable, exp, $time);
    end
  endtask

  // Drive one cycle at the falling edge, then sample just after the rising edge
  task automatic cyc(input bit spd, input bit pu, input bit pl, input bit pb);
    @(negedge clk);
    lowSpeed = spd; nullUpper = pu; nullLower = pl; lastBitPulse = pb;
    @(posedge clk);
    #1;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog expired in %s", curReq);
    finishRun();
  end

  initial begin
    // R1: reset state and immediate checking
    curReq = "R1";
    repeat (3) cyc(0, 1, 1, 0);
    expectEn(0, "R1");
    @(negedge clk);
    rstN = 1'b1; nullUpper = 1'b0; nullLower = 1'b0;
    @(posedge clk); #1;                       // edge 1 after reset
    expectEn(0, "R1");
    for (int k = 2; k <= 30; k++) begin
      cyc(0, (k % 10) == 0, (k % 10) == 0, 0);
      if (k == 29) expectEn(0, "R1");
    end
    expectEn(1, "R1");

    // R9: saturated, nulls absent for a long stretch
    curReq = "R9";
    for (int k = 1; k <= 50; k++) cyc(0, 0, 0, 0);
    expectEn(1, "R9");

    // R7: last-bit pulse drops enable
    curReq = "R7";
    cyc(0, 1, 1, 1);
    expectEn(0, "R7");

    // R2: high-speed period with nulls held high
    curReq = "R2";
    for (int k = 1; k <= 30; k++) begin
      cyc(0, 1, 1, 0);
      if (k == 29) expectEn(0, "R2");
    end
    expectEn(1, "R2");

    // R4 / R5: one-sided null fails, then three fresh passes needed
    curReq = "R4";
    cyc(0, 1, 1, 1);
    for (int k = 1; k <= 50; k++) begin
      cyc(0, 1, !(k == 20), 0);
      if (k == 30) expectEn(0, "R4");
      if (k == 49) expectEn(0, "R5");
    end
    expectEn(1, "R5");
    curReq = "R5";
    cyc(0, 1, 1, 1);
    for (int k = 1; k <= 40; k++) begin
      cyc(0, !(k == 10), 1, 0);
      if (k == 30) expectEn(0, "R5");
    end
    expectEn(1, "R5");

    // R6: nulls only on sampling edges, noise elsewhere
    curReq = "R6";
    cyc(0, 1, 1, 1);
    for (int k = 1; k <= 30; k++) begin
      cyc(0, (k % 10) == 0, ((k % 10) == 0) || (k % 7 == 0), 0);
    end
    expectEn(1, "R6");

    // R3: low speed (speed change and pulse together)
    curReq = "R3";
    cyc(1, 1, 1, 1);
    expectEn(0, "R3");
    for (int k = 1; k <= 240; k++) begin
      cyc(1, (k % 80) == 0, (k % 80) == 0, 0);
      if (k == 239) expectEn(0, "R3");
    end
    expectEn(1, "R3");

    // R8: speed change drops enable and restarts timing
    curReq = "R8";
    cyc(0, 1, 1, 0);
    expectEn(0, "R8");
    for (int k = 1; k <= 30; k++) begin
      cyc(0, 1, 1, 0);
      if (k == 29) expectEn(0, "R8");
    end
    expectEn(1, "R8");
    cyc(0, 1, 1, 1);
    for (int k = 1; k <= 15; k++) cyc(0, 1, 1, 0);
    cyc(1, 1, 1, 0);                         // mid-count change
    for (int k = 1; k <= 160; k++) cyc(1, 1, 1, 0);
    expectEn(0, "R8");
    for (int k = 161; k <= 240; k++) cyc(1, 1, 1, 0);
    expectEn(1, "R8");

    cyc(1, 0, 0, 0);
    finishRun();
  end

endmodule